// File: doc/BRIEF.md
# Power Event SCI Aggregator

This block collects power-management events and folds them into one level-sensitive system-control interrupt (SCI). Four fixed events (RTC alarm, power button, global lock, timer overflow) each have a status bit and an enable bit. Two hotplug summary events (PCI slot change, CPU change) land in a small general-purpose event window. The window holds two status bytes and two enable bytes. The SCI is high while either group has a status bit set whose enable bit is also set. The two groups are masked separately.

Software reaches the block through a byte-wide I/O bus. Reads are combinational and writes take effect on the clock edge. Status bits are write-1-to-clear, and enable bits are plain read/write. A command port switches a power-management mode bit on or off. When a configuration bit allows it, every command write also emits a one-cycle SMI pulse. The block gives the external timer an arm signal, and the timer overflow event is accepted only while that signal is high.

Top module: `pm_sci_agg`

## Requirements
- R1: Fixed status (address 0x0) has the timer at bit 0, global lock at bit 1, power button at bit 2 and RTC alarm at bit 3. Bits 7:4 always read 0. The fixed enable byte is at address 0x1. `sci` is high when any of status bits 3:0 is set together with the matching enable bit.
- R2: `sci` is also high when general-purpose status byte 0 ANDed with enable byte 0 has bit 1 set (PCI hotplug, set by `evt_pci_hp`) or bit 2 set (CPU hotplug, set by `evt_cpu_hp`).
- R3: The general-purpose window holds 4 bytes, accessed one byte at a time: status byte 0 at 0x4, status byte 1 at 0x5, enable byte 0 at 0x6, enable byte 1 at 0x7. A read returns the stored byte.
- R4: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Enable bytes store the written value.
- R5: When an event pulse and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R6: After a write or an event pulse, `sci` shows the new level in the very next cycle.
- R7: Writing 0xF1 to the command port (0x8) sets `pm_mode` and writing 0xF0 clears it. Any other value leaves it unchanged. Reading 0x8 returns `pm_mode` in bit 0.
- R8: A command-port write drives `smi_pulse` high for exactly the one cycle after the write edge, and only if bit 1 of the configuration byte (0x9) is set. Otherwise no pulse appears.
- R9: `tmr_arm` is high while timer enable is set and timer status is clear. A timer overflow pulse has no effect while `tmr_arm` is low.
- R10: Reset clears all status bytes, all enable bytes, the configuration byte and `pm_mode`. After reset, `sci`, `smi_pulse` and `tmr_arm` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address within the block |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| evt_rtc_alarm | input | 1 | RTC alarm event pulse |
| evt_pwr_btn | input | 1 | Power button event pulse |
| evt_glb_lock | input | 1 | Global lock event pulse |
| evt_tmr_ovf | input | 1 | Timer overflow event pulse |
| evt_pci_hp | input | 1 | PCI hotplug summary event pulse |
| evt_cpu_hp | input | 1 | CPU hotplug summary event pulse |
| tmr_arm | output | 1 | Timer overflow may be reported |
| pm_mode | output | 1 | Power-management mode bit |
| smi_pulse | output | 1 | One-cycle SMI request |
| sci | output | 1 | System-control interrupt level |

## Verification
The SCI level is computed directly from stored state, so a corrupted status or enable bit changes `sci` one cycle after the write or event that caused it. The same corruption shows up in the byte read back on the bus. Sweeping every fixed status/enable pair, and every hotplug status pair against every enable byte, exposes wrong bit positions and wrong masks at once. A lost event under a same-cycle clear, a missed timer gate, or an SMI pulse that is late, doubled or unconditional each shows up at the ports within two cycles of the access.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;

  localparam int BYTE_W = 8;

  // fixed-event status bit positions
  localparam int FX_TMR = 0;
  localparam int FX_GLK = 1;
  localparam int FX_PWR = 2;
  localparam int FX_RTC = 3;
  localparam logic [BYTE_W-1:0] FX_SCI_MASK = 8'h0F;

  // general-purpose status byte 0 bit positions
  localparam int GP_PCI = 1;
  localparam int GP_CPU = 2;
  localparam logic [BYTE_W-1:0] GP_SCI_MASK = 8'h06;

  // local byte addresses
  localparam int AD_FSTS = 0;
  localparam int AD_FEN  = 1;
  localparam int AD_GPE  = 4;
  localparam int AD_CMD  = 8;
  localparam int AD_CFG  = 9;

  localparam logic [BYTE_W-1:0] CMD_ON  = 8'hF1;
  localparam logic [BYTE_W-1:0] CMD_OFF = 8'hF0;
  localparam int CFG_SMI_BIT = 1;

  // next status value: clear the written ones, then let events win
  function automatic logic [BYTE_W-1:0] w1c_merge(input logic [BYTE_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] clr,
                                                  input logic [BYTE_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // any bit set in status, enabled, and counted by the mask
  function automatic logic masked_any(input logic [BYTE_W-1:0] sts,
                                      input logic [BYTE_W-1:0] en,
                                      input logic [BYTE_W-1:0] mask);
    return |(sts & en & mask);
  endfunction

endpackage

// File: rtl/pm_fixed_evt.sv
module pm_fixed_evt
  import pm_sci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sts,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              evt_rtc,
  input  logic              evt_pwr,
  input  logic              evt_glk,
  input  logic              evt_tmr,
  output logic [BYTE_W-1:0] sts,
  output logic [BYTE_W-1:0] en,
  output logic              tmr_armed,
  output logic              sci_fix
);

  logic [BYTE_W-1:0] sts_q, en_q, set_v, clr_v;

  assign tmr_armed = en_q[FX_TMR] & ~sts_q[FX_TMR];

  always_comb begin
    set_v         = '0;
    set_v[FX_TMR] = evt_tmr & tmr_armed;
    set_v[FX_GLK] = evt_glk;
    set_v[FX_PWR] = evt_pwr;
    set_v[FX_RTC] = evt_rtc;
    clr_v         = wr_sts ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= w1c_merge(sts_q, clr_v, set_v) & FX_SCI_MASK;
      if (wr_en) en_q <= wdata;
    end
  end

  assign sts     = sts_q;
  assign en      = en_q;
  assign sci_fix = masked_any(sts_q, en_q, FX_SCI_MASK);

  assert_fix_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pwr |=> sts_q[FX_PWR]);

  assert_tmr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_armed && !sts_q[FX_TMR]) |=> !sts_q[FX_TMR]);

  assert_fix_sci_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rtc && en_q[FX_RTC] && !wr_en) |=> sci_fix);

endmodule

// File: rtl/pm_gpe_win.sv
module pm_gpe_win
  import pm_sci_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [$clog2(2*NBYTES)-1:0] idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              evt_pci,
  input  logic              evt_cpu,
  output logic [BYTE_W-1:0] rdata,
  output logic              sci_gpe
);

  localparam int WIN   = 2 * NBYTES;
  localparam int IDX_W = $clog2(WIN);

  logic [NBYTES-1:0][BYTE_W-1:0] sts_v, en_v;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] s_r, e_r, set_b;
    logic wr_s, wr_e;

    assign wr_s = wr && (idx == IDX_W'(g));
    assign wr_e = wr && (idx == IDX_W'(g + NBYTES));

    if (g == 0) begin : g_src
      always_comb begin
        set_b         = '0;
        set_b[GP_PCI] = evt_pci;
        set_b[GP_CPU] = evt_cpu;
      end
    end else begin : g_nosrc
      assign set_b = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_r <= '0;
        e_r <= '0;
      end else begin
        s_r <= w1c_merge(s_r, wr_s ? wdata : '0, set_b);
        if (wr_e) e_r <= wdata;
      end
    end

    assign sts_v[g] = s_r;
    assign en_v[g]  = e_r;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx == IDX_W'(i))          rdata = sts_v[i];
      if (idx == IDX_W'(i + NBYTES)) rdata = en_v[i];
    end
  end

  assign sci_gpe = masked_any(sts_v[0], en_v[0], GP_SCI_MASK);

  assert_gpe_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pci |=> sts_v[0][GP_PCI]);

  assert_gpe_sci_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cpu && en_v[0][GP_CPU] && !(wr && idx == IDX_W'(NBYTES))) |=> sci_gpe);

endmodule

// File: rtl/pm_cmd_port.sv
module pm_cmd_port
  import pm_sci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_cfg,
  input  logic [BYTE_W-1:0] wdata,
  output logic              mode,
  output logic [BYTE_W-1:0] cfg,
  output logic              smi
);

  logic              mode_q, smi_q;
  logic [BYTE_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      cfg_q  <= '0;
      smi_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wdata;
      if (wr_cmd && wdata == CMD_ON)  mode_q <= 1'b1;
      if (wr_cmd && wdata == CMD_OFF) mode_q <= 1'b0;
      smi_q <= wr_cmd & cfg_q[CFG_SMI_BIT];
    end
  end

  assign mode = mode_q;
  assign cfg  = cfg_q;
  assign smi  = smi_q;

  assert_mode_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata == CMD_ON) |=> mode);

  assert_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata == CMD_OFF) |=> !mode);

  assert_smi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi |-> $past(wr_cmd && cfg[CFG_SMI_BIT]));

endmodule

// File: rtl/pm_sci_agg.sv
module pm_sci_agg
  import pm_sci_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int GPE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              evt_rtc_alarm,
  input  logic              evt_pwr_btn,
  input  logic              evt_glb_lock,
  input  logic              evt_tmr_ovf,
  input  logic              evt_pci_hp,
  input  logic              evt_cpu_hp,
  output logic              tmr_arm,
  output logic              pm_mode,
  output logic              smi_pulse,
  output logic              sci
);

  localparam int WIN   = 2 * GPE_BYTES;
  localparam int IDX_W = $clog2(WIN);

  logic              sel_fsts, sel_fen, sel_cmd, sel_cfg, sel_gpe;
  logic [IDX_W-1:0]  gpe_idx;
  logic [BYTE_W-1:0] fix_sts, fix_en, gpe_rd, cfg_byte;
  logic              sci_fix_w, sci_gpe_w;

  assign sel_fsts = io_addr == ADDR_W'(AD_FSTS);
  assign sel_fen  = io_addr == ADDR_W'(AD_FEN);
  assign sel_cmd  = io_addr == ADDR_W'(AD_CMD);
  assign sel_cfg  = io_addr == ADDR_W'(AD_CFG);
  assign sel_gpe  = (io_addr >= ADDR_W'(AD_GPE)) && (io_addr < ADDR_W'(AD_GPE + WIN));
  assign gpe_idx  = IDX_W'(io_addr - ADDR_W'(AD_GPE));

  pm_fixed_evt u_fix (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sts    (io_wr && sel_fsts),
    .wr_en     (io_wr && sel_fen),
    .wdata     (io_wdata),
    .evt_rtc   (evt_rtc_alarm),
    .evt_pwr   (evt_pwr_btn),
    .evt_glk   (evt_glb_lock),
    .evt_tmr   (evt_tmr_ovf),
    .sts       (fix_sts),
    .en        (fix_en),
    .tmr_armed (tmr_arm),
    .sci_fix   (sci_fix_w)
  );

  pm_gpe_win #(.NBYTES(GPE_BYTES)) u_gpe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (io_wr && sel_gpe),
    .idx     (gpe_idx),
    .wdata   (io_wdata),
    .evt_pci (evt_pci_hp),
    .evt_cpu (evt_cpu_hp),
    .rdata   (gpe_rd),
    .sci_gpe (sci_gpe_w)
  );

  pm_cmd_port u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_cmd (io_wr && sel_cmd),
    .wr_cfg (io_wr && sel_cfg),
    .wdata  (io_wdata),
    .mode   (pm_mode),
    .cfg    (cfg_byte),
    .smi    (smi_pulse)
  );

  assign sci = sci_fix_w | sci_gpe_w;

  always_comb begin
    io_rdata = '0;
    if (sel_fsts) io_rdata = fix_sts;
    if (sel_fen)  io_rdata = fix_en;
    if (sel_gpe)  io_rdata = gpe_rd;
    if (sel_cmd)  io_rdata = {7'b0, pm_mode};
    if (sel_cfg)  io_rdata = cfg_byte;
  end

  assert_rst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sci && !pm_mode && !smi_pulse && !tmr_arm));

  assert_sci_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sci && !io_wr) |=> sci);

endmodule

// File: tb/pm_sci_agg_bench.sv
`timescale 1ns/1ps
module pm_sci_agg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [5:0] ev = '0;   // [0]rtc [1]pwr [2]glk [3]tmr [4]pci [5]cpu
  logic       tmr_arm, pm_mode, smi_pulse, sci;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_sci_agg u_pm_sci_agg (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .evt_rtc_alarm(ev[0]), .evt_pwr_btn(ev[1]), .evt_glb_lock(ev[2]),
    .evt_tmr_ovf(ev[3]), .evt_pci_hp(ev[4]), .evt_cpu_hp(ev[5]),
    .tmr_arm(tmr_arm), .pm_mode(pm_mode), .smi_pulse(smi_pulse), .sci(sci)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ev(logic [3:0] a, logic [7:0] d, logic [5:0] m);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; ev = m;
    @(negedge clk);
    io_wr = 1'b0; ev = '0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_ev(a, d, 6'b0);
  endtask

  task automatic pulse(logic [5:0] m);
    @(negedge clk);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic rd(logic [3:0] a, int exp, string req);
    io_addr = a;
    #1;
    chk(req, int'(io_rdata), exp);
  endtask

  // fixed status pattern (bit0 tmr,1 glk,2 pwr,3 rtc) to event mask
  function automatic logic [5:0] fix_mask(logic [3:0] s);
    return {2'b00, s[0], s[1], s[2], s[3]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 sci", sci, 0);
    chk("R10 mode", pm_mode, 0);
    chk("R10 smi", smi_pulse, 0);
    chk("R10 arm", tmr_arm, 0);
    for (int a = 0; a < 10; a++) rd(4'(a), 0, "R10 regs");

    // R1 R4 R9 sweep of fixed status against fixed enable
    for (int s = 0; s < 16; s++) begin
      for (int e = 0; e < 16; e++) begin
        wr(4'h1, 8'h0F);
        wr(4'h0, 8'hFF);
        pulse(fix_mask(4'(s)));
        wr(4'h1, 8'(e));
        chk("R1 sci", sci, ((s & e) != 0) ? 1 : 0);
        rd(4'h0, s, "R4 fixed status");
        chk("R9 arm", tmr_arm, ((e & 1) != 0 && (s & 1) == 0) ? 1 : 0);
      end
    end
    wr(4'h1, 8'hF0);
    rd(4'h1, 8'hF0, "R4 fixed enable");
    chk("R1 upper enable ignored", sci, 0);
    wr(4'h0, 8'hFF);
    rd(4'h0, 0, "R4 cleared");
    wr(4'h1, 8'h00);

    // R9 timer gate
    pulse(6'b001000);
    rd(4'h0, 0, "R9 tmr ignored");
    wr(4'h1, 8'h01);
    chk("R9 armed", tmr_arm, 1);
    pulse(6'b001000);
    rd(4'h0, 1, "R9 tmr taken");
    chk("R9 disarmed", tmr_arm, 0);
    chk("R6 sci after tmr", sci, 1);
    wr(4'h0, 8'h01);
    chk("R4 w1c tmr", sci, 0);
    wr(4'h1, 8'h00);

    // R2 R3 sweep of hotplug status against enable byte 0
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 256; e++) begin
        wr(4'h4, 8'hFF);
        pulse({s[1], s[0], 4'b0});
        wr(4'h6, 8'(e));
        chk("R2 sci", sci, ((s * 2 & e) != 0) ? 1 : 0);
        rd(4'h4, s * 2, "R3 gpe status");
        rd(4'h6, e, "R3 gpe enable");
      end
    end
    wr(4'h7, 8'hA5);
    rd(4'h7, 8'hA5, "R3 enable byte 1");
    wr(4'h5, 8'hFF);
    rd(4'h5, 0, "R3 status byte 1");
    wr(4'h4, 8'hFF);
    wr(4'h6, 8'h00);

    // R5 event wins over same-cycle clear
    wr(4'h1, 8'h04);
    pulse(6'b000010);
    wr_ev(4'h0, 8'h04, 6'b000010);
    rd(4'h0, 8'h04, "R5 fixed event wins");
    chk("R5 sci", sci, 1);
    wr(4'h0, 8'h04);
    rd(4'h0, 0, "R5 clear alone");
    chk("R6 sci drop", sci, 0);
    wr(4'h6, 8'h02);
    pulse(6'b010000);
    wr_ev(4'h4, 8'h02, 6'b010000);
    rd(4'h4, 8'h02, "R5 gpe event wins");
    wr(4'h4, 8'h02);
    chk("R6 gpe sci drop", sci, 0);

    // R7 R8 command port
    wr(4'h8, 8'hF1);
    chk("R7 mode on", pm_mode, 1);
    chk("R8 no smi", smi_pulse, 0);
    rd(4'h8, 1, "R7 mode read");
    wr(4'h8, 8'h55);
    chk("R7 other code", pm_mode, 1);
    wr(4'h9, 8'h01);
    wr(4'h8, 8'hF0);
    chk("R8 wrong cfg bit", smi_pulse, 0);
    chk("R7 mode off", pm_mode, 0);
    wr(4'h9, 8'h02);
    wr(4'h8, 8'h33);
    chk("R8 smi pulse", smi_pulse, 1);
    @(negedge clk);
    chk("R8 smi one cycle", smi_pulse, 0);
    chk("R7 mode kept", pm_mode, 0);

    // R10 reset clears live state
    wr(4'h8, 8'hF1);
    wr(4'h1, 8'h0F);
    wr(4'h6, 8'h06);
    pulse(6'b110111);
    chk("R1 R2 pre-reset sci", sci, 1);
    do_reset();
    chk("R10 sci cleared", sci, 0);
    chk("R10 mode cleared", pm_mode, 0);
    rd(4'h0, 0, "R10 fixed status");
    rd(4'h1, 0, "R10 fixed enable");
    rd(4'h4, 0, "R10 gpe status");
    rd(4'h6, 0, "R10 gpe enable");
    rd(4'h9, 0, "R10 cfg");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule